// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the order in which columns are visited during one read or write burst of a synchronous DRAM. A start pulse loads a start column together with a three-bit length code and a one-bit ordering selector, both taken from the mode register settings. From the next cycle on, the block shows one column per cycle, raises a valid strobe for as long as the burst runs, and pulses a done flag alongside the final column.

Two orderings are supported. Sequential ordering counts upward and wraps inside the aligned block that the burst length defines. Interleaved ordering combines the start offset with a step counter by XOR. A page-length burst walks the whole row in sequential order, wraps around the row end and runs until it is stopped. A stop request ends a running burst early. A new start replaces a running burst at once. Length codes with no defined meaning are refused with an error pulse.

The block can sit inside a memory model to address the storage array, or inside a controller as the column counter of its data path.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `valid`, `done` and `cfg_err` are low.
- R2: A start sampled with a legal configuration makes `valid` high in the next cycle, and `col` in that cycle equals the sampled start column.
- R3: In sequential ordering (`burst_type` = 0), the low log2(BL) bits of the column step up by one each cycle and wrap within the aligned block. The upper bits keep the start column's value.
- R4: In interleaved ordering (`burst_type` = 1), the low log2(BL) bits in step k (k = 0 .. BL-1) equal the start column's low bits XOR k. The upper bits are held.
- R5: Length code 0, 1, 2 or 3 gives a burst of 1, 2, 4 or 8 columns. `valid` stays high for exactly that many cycles if nothing interrupts the burst.
- R6: `done` is high only in the cycle that shows the last column of a 1/2/4/8 burst. `valid` goes low in the cycle after it unless a new start arrives.
- R7: Length code 7 with sequential ordering gives a page burst. The column increments by one every cycle, wraps from 2^COL_W-1 to 0, never raises `done`, and runs until a stop or a new start.
- R8: A start with length code 4, 5 or 6, or with code 7 and interleaved ordering, raises `cfg_err` for one cycle. It leaves the block idle with `valid` low and aborts any running burst.
- R9: A stop sampled during a burst makes `valid` low in the next cycle. A stop while idle has no effect.
- R10: A start during a burst restarts it from the new start column at step 0. When start and stop are sampled in the same cycle, the start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new burst (one-cycle pulse) |
| start_col | input | COL_W | First column of the burst |
| len_code | input | 3 | Burst length code |
| burst_type | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| stop | input | 1 | Terminate the running burst |
| col | output | COL_W | Column for the current data beat |
| valid | output | 1 | A data beat is active in this cycle |
| done | output | 1 | Current beat is the last of a 1/2/4/8 burst |
| cfg_err | output | 1 | Previous start carried a reserved configuration |

## Verification
The cases that need care are those where two events land in the same cycle. A stop can arrive in the very cycle that `done` is shown, and a new start can coincide with a stop, with the last beat, or with a reserved code during a live burst. The bench drives these collisions directly, then adds a long randomized stretch in which start, stop, codes and ordering change freely. A behavioural model built on integer arithmetic (modulo and XOR of the offset) computes each beat, and `valid`, `col`, `done` and `cfg_err` are compared against it on every cycle. A collision counts as correctly handled when the outputs in the following cycle match the priority set out in R8 to R10.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    localparam logic [2:0] LC_BL1  = 3'd0;
    localparam logic [2:0] LC_BL2  = 3'd1;
    localparam logic [2:0] LC_BL4  = 3'd2;
    localparam logic [2:0] LC_BL8  = 3'd3;
    localparam logic [2:0] LC_PAGE = 3'd7;

    typedef struct packed {
        logic       legal;
        logic       page;
        logic [3:0] lg;
    } len_cfg_t;

    function automatic len_cfg_t decode_len(input logic [2:0] code, input order_e ord);
        len_cfg_t r;
        r = '0;
        case (code)
            LC_BL1:  begin r.legal = 1'b1; r.lg = 4'd0; end
            LC_BL2:  begin r.legal = 1'b1; r.lg = 4'd1; end
            LC_BL4:  begin r.legal = 1'b1; r.lg = 4'd2; end
            LC_BL8:  begin r.legal = 1'b1; r.lg = 4'd3; end
            LC_PAGE: begin r.legal = (ord == ORD_SEQ); r.page = (ord == ORD_SEQ); end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bcs_len_decode.sv
`timescale 1ns/1ps
module bcs_len_decode
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    input  order_e           ord,
    output logic             legal,
    output logic             page,
    output logic [COL_W-1:0] mask
);
    len_cfg_t cfg;

    always_comb begin
        cfg   = decode_len(len_code, ord);
        legal = cfg.legal;
        page  = cfg.page;
        if (cfg.page)
            mask = '1;
        else
            mask = COL_W'((32'd1 << cfg.lg) - 32'd1);
    end
endmodule

// File: rtl/bcs_ctrl.sv
`timescale 1ns/1ps
module bcs_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  order_e           ord_in,
    input  logic             cfg_legal,
    input  logic             cfg_page,
    input  logic [COL_W-1:0] cfg_mask,
    output logic             active,
    output logic             last,
    output logic             err,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] step_q,
    output logic [COL_W-1:0] mask_q,
    output order_e           ord_q
);
    logic page_q;

    assign last = active && !page_q && (step_q == mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            err    <= 1'b0;
            page_q <= 1'b0;
            base_q <= '0;
            step_q <= '0;
            mask_q <= '0;
            ord_q  <= ORD_SEQ;
        end else begin
            err <= start && !cfg_legal;
            if (start) begin
                if (cfg_legal) begin
                    active <= 1'b1;
                    step_q <= '0;
                    base_q <= start_col;
                    mask_q <= cfg_mask;
                    page_q <= cfg_page;
                    ord_q  <= ord_in;
                end else begin
                    active <= 1'b0;
                end
            end else if (active) begin
                if (stop || last)
                    active <= 1'b0;
                else
                    step_q <= step_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcs_addr_gen.sv
`timescale 1ns/1ps
module bcs_addr_gen
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] step,
    input  logic [COL_W-1:0] mask,
    input  order_e           ord,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_val;
    logic [COL_W-1:0] ilv_val;
    logic [COL_W-1:0] low_val;

    assign seq_val = base + step;
    assign ilv_val = base ^ step;
    assign low_val = (ord == ORD_ILV) ? ilv_val : seq_val;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = mask[i] ? low_val[i] : base[i];
    end
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       len_code,
    input  logic             burst_type,
    input  logic             stop,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             done,
    output logic             cfg_err
);
    order_e           ord_in;
    order_e           ord_q;
    logic             cfg_legal;
    logic             cfg_page;
    logic [COL_W-1:0] cfg_mask;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] step_q;
    logic [COL_W-1:0] mask_q;

    assign ord_in = order_e'(burst_type);

    bcs_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code (len_code),
        .ord      (ord_in),
        .legal    (cfg_legal),
        .page     (cfg_page),
        .mask     (cfg_mask)
    );

    bcs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .ord_in    (ord_in),
        .cfg_legal (cfg_legal),
        .cfg_page  (cfg_page),
        .cfg_mask  (cfg_mask),
        .active    (valid),
        .last      (done),
        .err       (cfg_err),
        .base_q    (base_q),
        .step_q    (step_q),
        .mask_q    (mask_q),
        .ord_q     (ord_q)
    );

    bcs_addr_gen #(.COL_W(COL_W)) u_gen (
        .base (base_q),
        .step (step_q),
        .mask (mask_q),
        .ord  (ord_q),
        .col  (col)
    );
endmodule

// File: rtl/bcs_chk.sv
`timescale 1ns/1ps
module bcs_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic [2:0]       len_code,
    input logic             burst_type,
    input logic             stop,
    input logic [COL_W-1:0] col,
    input logic             valid,
    input logic             done,
    input logic             cfg_err
);
    logic rsvd;
    logic page_run;

    assign rsvd = len_code[2] && ((len_code != 3'b111) || burst_type);

    always_ff @(posedge clk) begin
        if (rst)
            page_run <= 1'b0;
        else if (start)
            page_run <= !rsvd && (len_code == 3'b111);
    end

    AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
        (start && !rsvd) |=> (valid && col == $past(start_col)));          // R2
    AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (start && rsvd) |=> (cfg_err && !valid));                          // R8
    AST_STOP_CUTS: assert property (@(posedge clk) disable iff (rst)
        (valid && stop && !start) |=> !valid);                             // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!valid && !start) |=> (!valid && !done));                         // R9
    AST_DONE_LAST: assert property (@(posedge clk) disable iff (rst)
        (valid && done && !start) |=> !valid);                             // R6
    AST_DONE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        done |-> valid);                                                   // R6
    AST_PAGE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (valid && page_run) |-> !done);                                    // R7
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (valid && page_run && $past(valid) && !$past(start))
            |-> (col == COL_W'($past(col) + 1'b1)));                       // R7
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       burst_type = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col;
    logic       valid;
    logic       done;
    logic       cfg_err;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R1";
    bit    finished = 1'b0;

    // reference model state
    bit m_active = 0;
    bit m_err    = 0;
    bit m_page   = 0;
    bit m_ilv    = 0;
    int m_start  = 0;
    int m_bl     = 1;
    int m_k      = 0;

    always #5 clk = ~clk;

    burst_col_seq #(.COL_W(8)) u0 (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_code(len_code), .burst_type(burst_type), .stop(stop),
        .col(col), .valid(valid), .done(done), .cfg_err(cfg_err)
    );

    function automatic bit is_rsvd(input int code, input bit ilv);
        return (code >= 4 && code <= 6) || (code == 7 && ilv);
    endfunction

    function automatic int exp_col();
        int off;
        int base;
        if (m_page) return (m_start + m_k) % 256;
        off  = m_start % m_bl;
        base = m_start - off;
        if (!m_ilv) return base + ((off + m_k) % m_bl);
        return base + (off ^ m_k);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; m_err = 0; m_k = 0;
        end else if (start && is_rsvd(len_code, burst_type)) begin
            m_active = 0; m_err = 1;
        end else if (start) begin
            m_err = 0; m_active = 1; m_k = 0;
            m_start = start_col; m_ilv = burst_type;
            m_page = (len_code == 7);
            m_bl = m_page ? 256 : (1 << len_code);
        end else begin
            m_err = 0;
            if (m_active) begin
                if (stop) m_active = 0;
                else if (!m_page && m_k == m_bl - 1) m_active = 0;
                else m_k = (m_k + 1) % 256;
            end
        end
    end

    task automatic chk(input string t, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            if (rst) begin
                chk("R1", "valid", valid, 0);
                chk("R1", "done", done, 0);
                chk("R1", "cfg_err", cfg_err, 0);
            end else begin
                chk(tag, "valid", valid, m_active);
                chk(tag, "done", done, m_active && !m_page && m_k == m_bl - 1);
                chk(tag, "cfg_err", cfg_err, m_err);
                if (m_active) chk(tag, "col", col, exp_col());
            end
        end
    end

    task automatic cyc(input bit s, input int c, input int lc, input bit bt, input bit sp);
        @(posedge clk);
        #2;
        start = s; start_col = 8'(c); len_code = 3'(lc); burst_type = bt; stop = sp;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        tag = "R1"; idle(2);
        // R2 R3 R5 R6: sequential lengths with wrap in the aligned block
        tag = "R3";
        cyc(1, 8'h35, 3, 0, 0); idle(10);
        cyc(1, 8'h1B, 2, 0, 0); idle(6);
        tag = "R5";
        cyc(1, 8'h42, 0, 0, 0); idle(3);
        cyc(1, 8'h43, 1, 0, 0); idle(4);
        tag = "R2";
        for (int i = 0; i < 4; i++) cyc(1, 8'h80 + i, 0, 0, 0);
        idle(3);
        // R4: interleaved
        tag = "R4";
        cyc(1, 8'h12, 2, 1, 0); idle(6);
        cyc(1, 8'hA5, 3, 1, 0); idle(10);
        cyc(1, 8'h77, 1, 1, 0); idle(4);
        // R7: page burst with wrap, then stop
        tag = "R7";
        cyc(1, 8'hFD, 7, 0, 0); idle(262);
        cyc(0, 0, 0, 0, 1); idle(3);
        // R8: reserved codes, one aborting a burst
        tag = "R8";
        cyc(1, 8'h10, 4, 0, 0); idle(2);
        cyc(1, 8'h10, 6, 1, 0); idle(2);
        cyc(1, 8'h20, 3, 0, 0); idle(2);
        cyc(1, 8'h20, 7, 1, 0); idle(3);
        cyc(1, 8'h20, 5, 0, 0); idle(2);
        // R9: stop mid burst, stop on last beat, stop while idle
        tag = "R9";
        cyc(1, 8'h30, 3, 0, 0); idle(2);
        cyc(0, 0, 0, 0, 1); idle(3);
        cyc(1, 8'h31, 1, 0, 0); idle(1);
        cyc(0, 0, 0, 0, 1); idle(2);
        cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); idle(2);
        // R10: restart mid burst, start with stop, start on last beat
        tag = "R10";
        cyc(1, 8'h50, 3, 0, 0); idle(3);
        cyc(1, 8'h66, 2, 1, 0); idle(1);
        cyc(1, 8'h09, 3, 0, 1); idle(2);
        cyc(1, 8'hC4, 1, 0, 0); idle(1);
        cyc(1, 8'hC7, 1, 1, 0); idle(4);
        // R6: done collisions in a mixed random stretch
        tag = "R6";
        for (int i = 0; i < 3000; i++)
            cyc(($urandom % 4) == 0, $urandom % 256, $urandom % 8,
                $urandom % 2, ($urandom % 7) == 0);
        idle(10);
        finish_run();
    end
endmodule